// File: doc/BRIEF.md
# Processor Tick Timer

This block is a tick timer that a processor reaches through two word-wide registers: a free-running count and a mode word. The count advances by one on every cycle where the tick-enable input is high, at a nominal 20 MHz rate. A match occurs when a tick brings the low period-field bits of the count level with the period held in the mode word. The upper count bits take no part in the compare.

At a match, the pending flag in the mode word is set if interrupts are enabled. The level interrupt output always follows that flag. The two-bit mode then decides what the count does next:
- halt entirely;
- return to zero;
- freeze until software re-arms it;
- run on and wrap through the whole period field before the next match.

Software writes either register through a select line. A software write wins over any hardware change in the same cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the mode word reads 0 and irq is low.
- R2: A write with wrSel=0 loads the count and a write with wrSel=1 loads the mode word, both visible on the next cycle. rdData shows the count when rdSel=0 and the mode word when rdSel=1, combinationally. The mode word places the period in bits 27:0, pending in bit 28, enable in bit 29 and mode in bits 31:30.
- R3: With mode nonzero and not frozen, the count rises by one on each cycle with tickEn=1 and no write, and holds when tickEn=0. With mode 00 the count never changes without a write.
- R4: A match occurs on a tick whose incremented count has bits 27:0 equal to the period; bits 31:28 of the count are ignored.
- R5: On a match the pending bit (28) is set only when the enable bit (29) is 1; irq equals the pending bit.
- R6: The pending bit is sticky: it stays 1 until a mode-word write places 0 in bit 28.
- R7: In mode 01 (restart) the count becomes 0 on the matching tick.
- R8: In mode 10 (one-shot) the count keeps the matching value and ignores later ticks until a mode-word write with a nonzero mode re-arms it.
- R9: In mode 11 (continuous) the count takes the incremented value on a match and keeps counting, wrapping its low field, so the next match lies one full field wrap later.
- R10: In a cycle with any register write, no hardware count step, restart, freeze or pending update takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 count, 1 mode word |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read select: 0 count, 1 mode word |
| rdData | output | 32 | Selected register contents |
| tickEn | input | 1 | Timer tick qualifier |
| irq | output | 1 | Level interrupt, equal to pending bit |

## Verification
Every register change, whether written or caused by a tick, appears one clock edge after the cycle that carries the stimulus. The read mux and irq add no further register stage. The bench therefore drives each vector on a falling edge and lets one rising edge pass. It then samples count and irq on the next falling edge, where both results are due. Cases where a write and a matching tick fall in the same cycle are checked at that same edge, so that the suppressed hardware update would show as a count or irq mismatch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic ldCnt;
    logic ldMode;
    logic incCnt;
    logic clrCnt;
    logic setPend;
    logic setStop;
    logic clrStop;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [1:0]       wrMode,
  input  logic [1:0]       curMode,
  input  logic             enBit,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] cntLow,
  input  logic             stopQ,
  output tmrStrobe_t       strobe
);
  logic [PER_W-1:0] nextLow;
  logic             active;
  logic             step;
  logic             hit;
  tmrMode_e         modeE;

  always_comb begin
    modeE   = tmrMode_e'(curMode);
    nextLow = cntLow + 1'b1;
    active  = (modeE != MODE_OFF) && !stopQ;
    // hardware update only runs in a cycle with no software write
    step    = active && tickEn && !wrEn;
    hit     = step && (nextLow == period);

    strobe.ldCnt   = wrEn && !wrSel;
    strobe.ldMode  = wrEn && wrSel;
    strobe.clrStop = wrEn && wrSel && (wrMode != MODE_OFF);
    strobe.clrCnt  = hit && (modeE == MODE_RESTART);
    strobe.incCnt  = step && !strobe.clrCnt;
    strobe.setPend = hit && enBit;
    strobe.setStop = hit && (modeE == MODE_ONESHOT);
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] modeQ,
  output logic              stopQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int PER_W    = DATA_W - 4;
  localparam int PEND_BIT = PER_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      modeQ  <= '0;
      stopQ  <= 1'b0;
    end else begin
      if (strobe.ldCnt)       countQ <= wrData;
      else if (strobe.clrCnt) countQ <= '0;
      else if (strobe.incCnt) countQ <= countQ + 1'b1;

      if (strobe.ldMode)       modeQ <= wrData;
      else if (strobe.setPend) modeQ[PEND_BIT] <= 1'b1;

      if (strobe.clrStop)      stopQ <= 1'b0;
      else if (strobe.setStop) stopQ <= 1'b1;
    end
  end

  assign rdData = rdSel ? modeQ : countQ;
  assign irq    = modeQ[PEND_BIT];
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickEn,
  output logic              irq
);
  localparam int PER_W   = DATA_W - 4;
  localparam int EN_BIT  = PER_W + 1;
  localparam int MODE_LO = PER_W + 2;

  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] modeQ;
  logic              stopQ;

  tmr_ctrl #(.PER_W(PER_W)) u_ctrl (
    .tickEn (tickEn),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrMode (wrData[MODE_LO +: 2]),
    .curMode(modeQ[MODE_LO +: 2]),
    .enBit  (modeQ[EN_BIT]),
    .period (modeQ[PER_W-1:0]),
    .cntLow (countQ[PER_W-1:0]),
    .stopQ  (stopQ),
    .strobe (strobe)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdSel (rdSel),
    .countQ(countQ),
    .modeQ (modeQ),
    .stopQ (stopQ),
    .rdData(rdData),
    .irq   (irq)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              tickEn,
  input logic              irq,
  input logic [DATA_W-1:0] countQ,
  input logic [DATA_W-1:0] modeQ,
  input logic              stopQ
);
  localparam int PER_W    = DATA_W - 4;
  localparam int PEND_BIT = PER_W;
  localparam int EN_BIT   = PER_W + 1;
  localparam int MODE_LO  = PER_W + 2;

  // R2
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrSel |=> countQ == $past(wrData));

  // R3
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && !tickEn |=> $stable(countQ));

  // R3
  mode_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && modeQ[MODE_LO +: 2] == 2'b00 |=> $stable(countQ));

  // R5
  pend_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && !modeQ[EN_BIT] && !modeQ[PEND_BIT] |=> !irq);

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !wrEn |=> irq);

  // R8
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopQ && !wrEn |=> $stable(countQ));

  // R9
  cont_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && tickEn && modeQ[MODE_LO +: 2] == 2'b11 |=> countQ == $past(countQ) + 1'b1);
endmodule

bind tick_timer tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .wrSel (wrSel),
  .wrData(wrData),
  .tickEn(tickEn),
  .irq   (irq),
  .countQ(countQ),
  .modeQ (modeQ),
  .stopQ (stopQ)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        tickEn = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .tickEn(tickEn), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic        sel;
    logic [31:0] data;
    logic        tick;
    logic [31:0] expCnt;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 34;
  localparam vec_t VEC [0:NVEC-1] = '{
    '{3, 0, 0, 32'h0,         1, 32'h0,         0}, // R3 mode 00 holds
    '{10,1, 1, 32'hE000_0005, 1, 32'h0,         0}, // R10 write blocks tick
    '{3, 0, 0, 32'h0,         1, 32'h1,         0}, // R3
    '{3, 0, 0, 32'h0,         0, 32'h1,         0}, // R3 no tick holds
    '{3, 0, 0, 32'h0,         1, 32'h2,         0},
    '{3, 0, 0, 32'h0,         1, 32'h3,         0},
    '{3, 0, 0, 32'h0,         1, 32'h4,         0},
    '{5, 0, 0, 32'h0,         1, 32'h5,         1}, // R5 match sets pending
    '{9, 0, 0, 32'h0,         1, 32'h6,         1}, // R9 runs on, R6 sticky
    '{6, 1, 1, 32'hE000_0005, 0, 32'h6,         0}, // R6 cleared by write
    '{2, 1, 0, 32'h1000_0003, 0, 32'h1000_0003, 0}, // R2 count load
    '{4, 0, 0, 32'h0,         1, 32'h1000_0004, 0},
    '{4, 0, 0, 32'h0,         1, 32'h1000_0005, 1}, // R4 upper bits ignored
    '{2, 1, 1, 32'h4000_0003, 0, 32'h1000_0005, 0}, // R2 restart, enable off
    '{2, 1, 0, 32'h0,         0, 32'h0,         0},
    '{7, 0, 0, 32'h0,         1, 32'h1,         0},
    '{7, 0, 0, 32'h0,         1, 32'h2,         0},
    '{7, 0, 0, 32'h0,         1, 32'h0,         0}, // R7 restart, R5 no pend
    '{7, 0, 0, 32'h0,         1, 32'h1,         0},
    '{8, 1, 1, 32'hA000_0002, 0, 32'h1,         0}, // one-shot, period 2
    '{8, 0, 0, 32'h0,         1, 32'h2,         1}, // R8 match freezes
    '{8, 0, 0, 32'h0,         1, 32'h2,         1}, // R8 tick ignored
    '{8, 0, 0, 32'h0,         1, 32'h2,         1},
    '{8, 1, 1, 32'hA000_0002, 1, 32'h2,         0}, // R8 re-arm
    '{8, 0, 0, 32'h0,         1, 32'h3,         0}, // R8 counts again
    '{8, 0, 0, 32'h0,         1, 32'h4,         0},
    '{9, 1, 1, 32'hE000_0000, 0, 32'h4,         0}, // continuous, period 0
    '{9, 1, 0, 32'h1FFF_FFFE, 0, 32'h1FFF_FFFE, 0},
    '{9, 0, 0, 32'h0,         1, 32'h1FFF_FFFF, 0},
    '{9, 0, 0, 32'h0,         1, 32'h2000_0000, 1}, // R9 field wrap match
    '{10,1, 1, 32'hE000_0003, 0, 32'h2000_0000, 0},
    '{10,1, 0, 32'h2,         0, 32'h2,         0},
    '{10,1, 0, 32'h55,        1, 32'h55,        0}, // R10 write beats match
    '{10,0, 0, 32'h0,         1, 32'h56,        0}
  };

  task automatic check(input string req, input [31:0] got, input [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdSel = 1'b0; #1 check("R1 count", rdData, 32'h0);
    rdSel = 1'b1; #1 check("R1 mode", rdData, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rdSel = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      wrEn   = VEC[i].wr;
      wrSel  = VEC[i].sel;
      wrData = VEC[i].data;
      tickEn = VEC[i].tick;
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0;
      tickEn = 1'b0;
      #1;
      check($sformatf("R%0d vec %0d count", VEC[i].req, i), rdData, VEC[i].expCnt);
      check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'h0, irq}, {31'h0, VEC[i].expIrq});
    end

    // R2 mode word read-back and combinational read select
    rdSel = 1'b1; #1 check("R2 mode readback", rdData, 32'hE000_0003);
    rdSel = 1'b0; #1 check("R2 count readback", rdData, 32'h56);

    // R6 pending survives count writes, cleared only via mode word
    wrEn = 1'b1; wrSel = 1'b0; wrData = 32'h2; tickEn = 1'b0;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b1;
    @(posedge clk); @(negedge clk);
    tickEn = 1'b0;
    #1 check("R5 irq set", {31'h0, irq}, 32'h1);
    wrEn = 1'b1; wrSel = 1'b0; wrData = 32'h0;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    #1 check("R6 count write keeps pending", {31'h0, irq}, 32'h1);

    // R1 reset mid-run
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    rdSel = 1'b1; #1 check("R1 mode after reset", rdData, 32'h0);
    rdSel = 1'b0; #1 check("R1 count after reset", rdData, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    finishRun();
  end
endmodule